// File: doc/BRIEF.md
# Triangular Spread-Spectrum Profile Controller

This block produces the digital control word that steers a fractional-N frequency synthesizer so the synthesized clock sweeps back and forth around its nominal frequency. Spreading the energy over a band in this way lowers the peak emission at the fundamental and at its harmonics. On each update tick the block registers a new word, nominal plus a signed offset. Over time the offset traces a linear triangle at about 31.5 kHz.

The offset scales with the nominal word, so one setting gives the same relative spread anywhere in the 3 to 200 MHz output range. Two shapes are available. Center spread swings symmetrically above and below nominal. Down spread swings only below nominal. The magnitude is a code in units of 0.25 %, and a code outside the range legal for the chosen shape is clamped. An active-low spread input switches modulation on or off. While modulation is off the output holds the plain nominal word. Shape, magnitude and nominal word are taken only where the profile crosses zero, at the start of each modulation period.

Top module: `ssm_modulator`

## Requirements
- R1: While reset is active and in the cycle after it is released, `mod_word_o` is 0 and `upd_o` is 0.
- R2: `upd_o` is a one-cycle pulse. It repeats every TICK_DIV = round(CLK_HZ / (MOD_HZ * 2 * HALF_STEPS)) clocks, which is 25 at the default parameters. A full profile is 2*HALF_STEPS ticks (1600 clocks, 31.25 kHz), which lies inside 30 to 33 kHz.
- R3: With `spread_en_n_i` = 1 (modulation off), the word registered at each tick equals the `nom_word_i` sampled at that tick.
- R4: Center mode (`mode_down_i` = 0). The step is s = floor(nom * code * 2 / (400 * HALF_STEPS)). At tick k (1..2H, H = HALF_STEPS) of a period the word is nom + s*p(k). Here p(k) = k for k <= H/2, H-k for k <= 3H/2, and k-2H otherwise. The peaks are +s*H/2 and -s*H/2.
- R5: Down mode (`mode_down_i` = 1). The step is s = floor(nom * code / (400 * H)). At tick k the word is nom - s*k for k <= H and nom - s*(2H-k) after that, so it never exceeds nom.
- R6: In center mode a code below 1 is used as 1, and a code above 10 (2.5 %) is used as 10.
- R7: In down mode a code below 2 (0.5 %) is used as 2, and a code above 20 (5.0 %) is used as 20.
- R8: Changes to mode, code or nominal word in the middle of a period have no effect until the period ends. The next period uses the values present at its first tick.
- R9: If spread is disabled at a tick, the word at that tick is the nominal word and the profile returns to its zero point. After re-enable, the first tick gives nom+s in center mode or nom-s in down mode.
- R10: `mod_word_o` changes only in the cycle in which `upd_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nom_word_i | input | WORD_W | Nominal (unmodulated) control word |
| mode_down_i | input | 1 | 0 = center spread, 1 = down spread |
| spread_code_i | input | 5 | Spread magnitude in units of 0.25 % |
| spread_en_n_i | input | 1 | 0 = modulation on, 1 = modulation off |
| mod_word_o | output | WORD_W | Registered modulated control word |
| upd_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench sweeps every magnitude code from 0 to 12 in center mode and from 0 to 21 in down mode, and checks every tick of each period against the arithmetic triangle. This shows whether the peaks and the slope are right and whether the clamp limits sit at the correct codes. A change injected mid-period, with a new mode, code and nominal word, shows that the profile keeps its old shape until the zero crossing. Disabling spread mid-period and re-enabling it in each mode shows that the output returns cleanly to nominal and restarts in the right direction. Runs with modulation off and a changing nominal word show the pass-through behaviour and the tick spacing.

// File: rtl/ssm_pkg.sv
// Package: shared encodings and magnitude-code limits for the spread controller.
// Assumes magnitude codes count 0.25 % units (1/400 of the nominal word).
package ssm_pkg;

    localparam int unsigned CODE_W     = 5;
    localparam int unsigned GRID_DEN   = 400;
    localparam int unsigned CENTER_MIN = 1;
    localparam int unsigned CENTER_MAX = 10;
    localparam int unsigned DOWN_MIN   = 2;
    localparam int unsigned DOWN_MAX   = 20;

    typedef enum logic {
        SHAPE_CENTER = 1'b0,
        SHAPE_DOWN   = 1'b1
    } spread_shape_e;

    // Limit a magnitude code to the legal range of the selected shape.
    function automatic logic [CODE_W-1:0] clamp_code(input logic down,
                                                     input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] lo;
        logic [CODE_W-1:0] hi;
        lo = down ? CODE_W'(DOWN_MIN) : CODE_W'(CENTER_MIN);
        hi = down ? CODE_W'(DOWN_MAX) : CODE_W'(CENTER_MAX);
        if (code < lo)      return lo;
        else if (code > hi) return hi;
        else                return code;
    endfunction

endpackage

// File: rtl/ssm_tick_gen.sv
// Module: update-tick divider. Emits a one-cycle tick every DIV clocks, with DIV
// chosen so that 2*HALF_STEPS ticks come as close as possible to one modulation period.
// Assumes DIV evaluates to at least 2.
module ssm_tick_gen #(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned MOD_HZ     = 31_500,
    parameter int unsigned HALF_STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned DIV   = (CLK_HZ + MOD_HZ * HALF_STEPS) / (MOD_HZ * 2 * HALF_STEPS);
    localparam int unsigned CNT_W = $clog2(DIV);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = (cnt_q == CNT_W'(DIV - 1));

    // Free-running divide counter, wrapping at the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ssm_step_calc.sv
// Module: per-tick step size. Clamps the magnitude code for the selected shape
// and scales the nominal word by code/400. Center mode doubles the step because
// it covers twice the span in the same half period.
// Assumes the constant divisor GRID_DEN*HALF_STEPS; the logic is purely combinational.
module ssm_step_calc
    import ssm_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned HALF_STEPS = 32
) (
    input  logic              mode_down_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [WORD_W-1:0] nom_i,
    output logic [WORD_W-1:0] step_o
);
    localparam int unsigned PW  = WORD_W + CODE_W + 1;
    localparam int unsigned DEN = GRID_DEN * HALF_STEPS;

    logic [CODE_W-1:0] code_c;
    logic [PW-1:0]     prod;
    logic [PW-1:0]     scaled;
    logic [PW-1:0]     quot;

    // Clamp the code, scale the nominal word by it and divide down to one tick's step.
    always_comb begin
        code_c = clamp_code(mode_down_i, code_i);
        prod   = PW'(nom_i) * PW'(code_c);
        scaled = mode_down_i ? prod : (prod << 1);
        quot   = scaled / PW'(DEN);
        step_o = quot[WORD_W-1:0];
    end
endmodule

// File: rtl/ssm_tri_acc.sv
// Module: triangle accumulator. Adds or subtracts the step on each tick, with the
// direction taken from the phase within the period. Shape and step are taken only
// at phase 0, the zero crossing. While not running it holds phase and offset at zero.
// Assumes HALF_STEPS is even and at least 2.
module ssm_tri_acc #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned HALF_STEPS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_i,
    input  logic                     run_i,
    input  logic                     mode_down_i,
    input  logic [WORD_W-1:0]        step_i,
    output logic                     at_zero_o,
    output logic signed [WORD_W:0]   acc_next_o,
    output logic                     active_o,
    output logic                     mode_down_o,
    output logic [WORD_W-1:0]        step_o
);
    localparam int unsigned PERIOD = 2 * HALF_STEPS;
    localparam int unsigned QW     = $clog2(PERIOD);
    localparam int unsigned Q1     = HALF_STEPS / 2;
    localparam int unsigned Q3     = (3 * HALF_STEPS) / 2;

    logic [QW-1:0]          phase_q;
    logic signed [WORD_W:0] acc_q;
    logic                   mode_q;
    logic [WORD_W-1:0]      step_q;
    logic                   active_q;
    logic                   mode_use;
    logic [WORD_W-1:0]      step_use;
    logic                   rising;
    logic signed [WORD_W:0] step_s;

    assign at_zero_o   = (phase_q == '0);
    assign active_o    = active_q;
    assign mode_down_o = mode_q;
    assign step_o      = step_q;

    // Choose the settings in force and the slope direction for this tick.
    always_comb begin
        mode_use = at_zero_o ? mode_down_i : mode_q;
        step_use = at_zero_o ? step_i      : step_q;
        if (mode_use) rising = (phase_q >= QW'(HALF_STEPS));
        else          rising = (phase_q < QW'(Q1)) || (phase_q >= QW'(Q3));
        step_s     = $signed({1'b0, step_use});
        acc_next_o = rising ? (acc_q + step_s) : (acc_q - step_s);
    end

    // Advance the phase and the offset on each tick, or park both at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '0;
            acc_q    <= '0;
            mode_q   <= 1'b0;
            step_q   <= '0;
            active_q <= 1'b0;
        end else if (tick_i) begin
            if (run_i) begin
                phase_q  <= (phase_q == QW'(PERIOD - 1)) ? '0 : phase_q + 1'b1;
                acc_q    <= acc_next_o;
                active_q <= 1'b1;
                if (at_zero_o) begin
                    mode_q <= mode_down_i;
                    step_q <= step_i;
                end
            end else begin
                phase_q  <= '0;
                acc_q    <= '0;
                active_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ssm_modulator.sv
// Module: top of the spread-spectrum profile controller. Ties together the tick
// divider, step calculation and triangle accumulator, and registers
// nominal + offset on each tick with a matching update strobe.
// Assumes nom_word_i has headroom for +2.5 % (no wrap on the top peak).
module ssm_modulator
    import ssm_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned MOD_HZ     = 31_500,
    parameter int unsigned HALF_STEPS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] nom_word_i,
    input  logic              mode_down_i,
    input  logic [CODE_W-1:0] spread_code_i,
    input  logic              spread_en_n_i,
    output logic [WORD_W-1:0] mod_word_o,
    output logic              upd_o
);
    logic                   tick;
    logic [WORD_W-1:0]      step_w;
    logic                   at_zero;
    logic signed [WORD_W:0] acc_next;
    logic                   active_q;
    logic                   mode_q;
    logic [WORD_W-1:0]      step_q;
    logic [WORD_W-1:0]      nom_q;
    logic [WORD_W-1:0]      nom_use;
    logic [WORD_W+1:0]      sum;
    logic                   run;

    assign run = ~spread_en_n_i;

    ssm_tick_gen #(
        .CLK_HZ(CLK_HZ), .MOD_HZ(MOD_HZ), .HALF_STEPS(HALF_STEPS)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    ssm_step_calc #(
        .WORD_W(WORD_W), .HALF_STEPS(HALF_STEPS)
    ) u_step (
        .mode_down_i(mode_down_i), .code_i(spread_code_i),
        .nom_i(nom_word_i), .step_o(step_w)
    );

    ssm_tri_acc #(
        .WORD_W(WORD_W), .HALF_STEPS(HALF_STEPS)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run),
        .mode_down_i(mode_down_i), .step_i(step_w),
        .at_zero_o(at_zero), .acc_next_o(acc_next), .active_o(active_q),
        .mode_down_o(mode_q), .step_o(step_q)
    );

    // Nominal word in force this tick and the offset added to it.
    always_comb begin
        nom_use = at_zero ? nom_word_i : nom_q;
        sum     = {2'b00, nom_use} + {acc_next[WORD_W], acc_next};
    end

    // Register the output word, the nominal word in force and the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_word_o <= '0;
            nom_q      <= '0;
            upd_o      <= 1'b0;
        end else begin
            upd_o <= tick;
            if (tick) begin
                if (run) begin
                    mod_word_o <= sum[WORD_W-1:0];
                    if (at_zero) nom_q <= nom_word_i;
                end else begin
                    mod_word_o <= nom_word_i;
                    nom_q      <= nom_word_i;
                end
            end
        end
    end
endmodule

// File: rtl/ssm_modulator_chk.sv
// Module: property checker for ssm_modulator, attached by bind below.
// Assumes the default tick divider evaluates to at least 2.
module ssm_modulator_chk #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned MOD_HZ     = 31_500,
    parameter int unsigned HALF_STEPS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              spread_en_n_i,
    input logic [WORD_W-1:0] nom_word_i,
    input logic [WORD_W-1:0] mod_word_o,
    input logic              upd_o,
    input logic [WORD_W-1:0] nom_q,
    input logic              mode_q,
    input logic [WORD_W-1:0] step_q,
    input logic              active_q
);
    localparam int unsigned DIV = (CLK_HZ + MOD_HZ * HALF_STEPS) / (MOD_HZ * 2 * HALF_STEPS);
    localparam int unsigned SW  = WORD_W + 16;

    logic [15:0]   gap_q;
    logic          seen_q;
    logic [SW-1:0] span;
    logic [SW-1:0] hi_lim;
    logic [SW-1:0] lo_lim;
    logic [SW-1:0] word_x;

    // Count the clocks since the previous strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (upd_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Envelope of the center-spread profile around the nominal word in force.
    always_comb begin
        span   = SW'(step_q) * SW'(HALF_STEPS / 2);
        hi_lim = SW'(nom_q) + span;
        lo_lim = SW'(nom_q) - span;
        word_x = SW'(mod_word_o);
    end

    assert_upd_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && seen_q) |-> (gap_q == 16'(DIV - 1)));

    assert_upd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    assert_off_nominal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && spread_en_n_i) |=> (mod_word_o == $past(nom_word_i)));

    assert_center_envelope_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && active_q && !mode_q) |-> (word_x <= hi_lim && word_x >= lo_lim));

    assert_down_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && active_q && mode_q) |-> (mod_word_o <= nom_q));

    assert_word_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable(mod_word_o));
endmodule

bind ssm_modulator ssm_modulator_chk #(
    .WORD_W(WORD_W), .CLK_HZ(CLK_HZ), .MOD_HZ(MOD_HZ), .HALF_STEPS(HALF_STEPS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .spread_en_n_i(spread_en_n_i),
    .nom_word_i(nom_word_i), .mod_word_o(mod_word_o), .upd_o(upd_o),
    .nom_q(nom_q), .mode_q(mode_q), .step_q(step_q), .active_q(active_q)
);

// File: tb/ssm_modulator_tb.sv
module ssm_modulator_tb;
    localparam int H     = 32;
    localparam int DIV   = 25;
    localparam logic [31:0] NOM_A = 32'h1000_0000;
    localparam logic [31:0] NOM_B = 32'd100_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] nom_word_i = NOM_A;
    logic        mode_down_i = 1'b0;
    logic [4:0]  spread_code_i = 5'd0;
    logic        spread_en_n_i = 1'b1;
    logic [31:0] mod_word_o;
    logic        upd_o;

    int checks = 0;
    int fails  = 0;
    int stab_err = 0;

    always #10 clk = ~clk;

    ssm_modulator u_dut (
        .clk(clk), .rst_n(rst_n), .nom_word_i(nom_word_i), .mode_down_i(mode_down_i),
        .spread_code_i(spread_code_i), .spread_en_n_i(spread_en_n_i),
        .mod_word_o(mod_word_o), .upd_o(upd_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Wait until the next strobe; any word change in between counts against R10.
    task automatic wait_upd();
        logic [31:0] prev;
        prev = mod_word_o;
        forever begin
            @(negedge clk);
            if (upd_o) return;
            if (mod_word_o !== prev) stab_err++;
        end
    endtask

    function automatic int clamp_m(input logic dn, input int c);
        int lo = dn ? 2 : 1;
        int hi = dn ? 20 : 10;
        if (c < lo) return lo;
        if (c > hi) return hi;
        return c;
    endfunction

    function automatic longint step_m(input logic dn, input int c, input logic [31:0] nom);
        longint p = longint'(nom) * longint'(clamp_m(dn, c)) * (dn ? 1 : 2);
        return p / (400 * H);
    endfunction

    function automatic int pos_m(input logic dn, input int k);
        if (dn) return (k <= H) ? -k : (k - 2 * H);
        if (k <= H / 2) return k;
        if (k <= 3 * H / 2) return H - k;
        return k - 2 * H;
    endfunction

    // One modulation period from its zero crossing; optional mid-period input change.
    task automatic run_period(input logic dn, input int c, input logic [31:0] nom,
                              input int chg_k, input logic dn2, input int c2,
                              input logic [31:0] nom2, input int stop_k, input string tag);
        longint s;
        mode_down_i   = dn;
        spread_code_i = 5'(c);
        nom_word_i    = nom;
        spread_en_n_i = 1'b0;
        s = step_m(dn, c, nom);
        for (int k = 1; k <= stop_k; k++) begin
            wait_upd();
            check(tag, longint'(mod_word_o), longint'(nom) + s * pos_m(dn, k));
            if (k == chg_k) begin
                mode_down_i   = dn2;
                spread_code_i = 5'(c2);
                nom_word_i    = nom2;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int gap;
        repeat (4) @(negedge clk);
        check("R1 word in reset", longint'(mod_word_o), 0);
        check("R1 strobe in reset", longint'(upd_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 word after release", longint'(mod_word_o), 0);
        check("R1 strobe after release", longint'(upd_o), 0);

        // Modulation off: pass-through of the nominal word (R3).
        wait_upd();
        check("R3 off word A", longint'(mod_word_o), longint'(NOM_A));
        nom_word_i = NOM_B;
        wait_upd();
        check("R3 off word B", longint'(mod_word_o), longint'(NOM_B));

        // Strobe spacing and full-period length (R2).
        gap = 0;
        do begin @(negedge clk); gap++; end while (!upd_o);
        check("R2 tick spacing", gap, DIV);
        gap = 0;
        for (int k = 0; k < 2 * H; k++) begin
            do begin @(negedge clk); gap++; end while (!upd_o);
        end
        check("R2 period clocks", gap, 2 * H * DIV);
        check("R2 rate in band", ((50_000_000 / gap) >= 30000 && (50_000_000 / gap) <= 33000) ? 1 : 0, 1);
        check("R3 off word held", longint'(mod_word_o), longint'(NOM_B));

        // Center sweep, codes 0..12 (R4 shape, R6 clamp).
        for (int c = 0; c <= 12; c++)
            run_period(1'b0, c, NOM_A, 0, 1'b0, 0, 0, 2 * H,
                       (c < 1 || c > 10) ? "R6 center clamp" : "R4 center profile");
        // Down sweep, codes 0..21 (R5 shape, R7 clamp).
        for (int c = 0; c <= 21; c++)
            run_period(1'b1, c, NOM_B, 0, 1'b0, 0, 0, 2 * H,
                       (c < 2 || c > 20) ? "R7 down clamp" : "R5 down profile");

        // Mid-period change held off until the zero crossing (R8).
        run_period(1'b0, 8, NOM_A, 20, 1'b1, 15, NOM_B, 2 * H, "R8 old settings kept");
        run_period(1'b1, 15, NOM_B, 0, 1'b0, 0, 0, 2 * H, "R8 new settings applied");

        // Disable mid-period and restart in both directions (R9).
        run_period(1'b0, 10, NOM_B, 0, 1'b0, 0, 0, 21, "R9 before disable");
        spread_en_n_i = 1'b1;
        wait_upd();
        check("R9 disabled to nominal", longint'(mod_word_o), longint'(NOM_B));
        wait_upd();
        check("R9 stays nominal", longint'(mod_word_o), longint'(NOM_B));
        run_period(1'b1, 20, NOM_A, 0, 1'b0, 0, 0, 2 * H, "R9 down restart");
        run_period(1'b1, 6, NOM_A, 0, 1'b0, 0, 0, 40, "R9 before second disable");
        spread_en_n_i = 1'b1;
        wait_upd();
        check("R9 disabled from down", longint'(mod_word_o), longint'(NOM_A));
        run_period(1'b0, 4, NOM_A, 0, 1'b0, 0, 0, 2 * H, "R9 center restart");

        check("R10 word changes only on strobe", stab_err, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule